// File: doc/BRIEF.md
# Write-Protected Watchdog Timer with Unlock and Settle Handshake

The block is a watchdog timer whose configuration is guarded. Its control word and its timeout limit can be changed only inside a short window that software opens by writing a key sequence to the counter location. Software first waits for a read-only "open" flag. It then makes exactly one configuration write and polls a read-only "settled" flag until the new value has taken effect. Clearing the update-permit bit seals the configuration until the next reset.

Once enabled, the timer counts a slow tick, supplied as a one-cycle enable, up to the timeout limit and raises `expired` when it gets there. Software keeps it alive by writing a refresh key to the counter location. Two per-mode run bits let counting continue while the external wait or stop indications are high; when the matching run bit is clear, that mode freezes the count. The register bus is a single-cycle 32-bit write port with a combinational read port.

Top module: `guarded_wdog`

## Requirements
- R1: After reset, offset 0x0 reads 0x00000420: the update-permit bit (bit 5) and the settled flag (bit 10) are set, and the enable (bit 7), wait-run (bit 1), stop-run (bit 0), 32-bit-key (bit 13) and open flag (bit 11) are clear. Offset 0x4 reads 0, offset 0x8 reads the reset timeout, and `expired` is low.
- R2: With bit 13 clear, writing 0x6A1C and then 0x95E3 in the low 16 bits of two consecutive writes to offset 0x4 sets the open flag (bit 11) after the second write's clock edge. Any other counter write in between, or the second key written alone, leaves the flag clear.
- R3: With bit 13 set, a single write of 0x95E36A1C to offset 0x4 sets the open flag, and the 16-bit key pair does not. With bit 13 clear, the 32-bit key alone does not set it.
- R4: A write to offset 0x0 or 0x8 while the open flag reads 0 changes neither register.
- R5: The open flag stays set for exactly UNLOCK_WIN clock cycles after the unlocking edge. A write to 0x0 or 0x8 is accepted only in a cycle where the flag reads 1, and one accepted write clears the flag, so a second write is ignored.
- R6: An accepted configuration write clears the settled flag (bit 10) at its clock edge. The flag returns to 1 exactly SETTLE_CYC cycles later, and only then do reads of the target register show the new value.
- R7: Once a committed control word has bit 5 clear, key writes no longer set the open flag until reset, and writes to the timeout register are ignored.
- R8: While enabled, the count at offset 0x4 rises by one on each clock edge where `tick_en` is high. While disabled, it reads 0.
- R9: When `wait_mode` is high, counting happens only if wait-run is set. When `stop_mode` is high, counting happens only if stop-run is set. When both are high, both bits are needed.
- R10: The count stops at the timeout value, and `expired` is high exactly while the timer is enabled and the count has reached the timeout value.
- R11: Writing 0xB480A602 to offset 0x4 while enabled returns the count to 0 and drops `expired`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset (0x0 control, 0x4 counter, 0x8 timeout) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_en | input | 1 | Slow-tick enable, one count per high cycle |
| wait_mode | input | 1 | External wait-mode indication |
| stop_mode | input | 1 | External stop-mode indication |
| expired | output | 1 | Timeout reached while enabled |

## Verification
The bench builds the block with an 8-bit counter, a 6-cycle unlock window, a 3-cycle settle delay and a reset timeout of 20. These small values make it possible to sweep the write delay after an unlock over every cycle of the window and one step past its end. They also let the bench check each cycle of the settle interval individually. For several small timeout values, it runs every tick count from zero to past the limit. It also covers all sixteen combinations of the two run bits and the two mode inputs.

// File: rtl/wdg_pkg.sv
// Shared definitions for the guarded watchdog: bus offsets, key values,
// control bit positions and the control word type.
package wdg_pkg;

    localparam logic [3:0]  OFF_CTRL  = 4'h0;
    localparam logic [3:0]  OFF_CNT   = 4'h4;
    localparam logic [3:0]  OFF_TOVAL = 4'h8;

    localparam logic [15:0] KEY_FIRST   = 16'h6A1C;
    localparam logic [15:0] KEY_SECOND  = 16'h95E3;
    localparam logic [31:0] KEY_WORD    = 32'h95E3_6A1C;
    localparam logic [31:0] KEY_REFRESH = 32'hB480_A602;

    localparam int B_STOP_RUN = 0;
    localparam int B_WAIT_RUN = 1;
    localparam int B_UPD      = 5;
    localparam int B_EN       = 7;
    localparam int B_SETTLED  = 10;
    localparam int B_OPEN     = 11;
    localparam int B_KEY32    = 13;

    typedef struct packed {
        logic key32;
        logic en;
        logic upd;
        logic wait_run;
        logic stop_run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{key32: 1'b0, en: 1'b0, upd: 1'b1,
                                     wait_run: 1'b0, stop_run: 1'b0};

endpackage

// File: rtl/wdg_unlock.sv
// Key-sequence detector and unlock window.
// Assumes: cnt_wr is a write to the counter offset, and cfg_hit is a
// configuration write that the top has already accepted. Keys are ignored
// once the committed update-permit bit is clear.
module wdg_unlock
    import wdg_pkg::*;
#(
    parameter int UNLOCK_WIN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_wr,
    input  logic [31:0] wdata,
    input  logic        key32,
    input  logic        upd,
    input  logic        cfg_hit,
    output logic        unlocked
);
    localparam int WW = $clog2(UNLOCK_WIN + 1);

    logic          half_seen;
    logic [WW-1:0] win_left;
    logic          key_done;

    // Unlock completes on the 32-bit key or on the second half of the pair.
    always_comb begin
        if (key32)
            key_done = upd && cnt_wr && (wdata == KEY_WORD);
        else
            key_done = upd && cnt_wr && half_seen && (wdata[15:0] == KEY_SECOND);
    end

    // Remember a first key half; any other counter write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_seen <= 1'b0;
        else if (cnt_wr)
            half_seen <= !key32 && upd && (wdata[15:0] == KEY_FIRST);
    end

    // Open the window on a key, close it after a write or when time runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            win_left <= '0;
        end else if (key_done) begin
            unlocked <= 1'b1;
            win_left <= WW'(UNLOCK_WIN - 1);
        end else if (unlocked) begin
            if (cfg_hit || win_left == '0)
                unlocked <= 1'b0;
            else
                win_left <= win_left - 1'b1;
        end
    end

endmodule

// File: rtl/wdg_cfg.sv
// Configuration stage: holds the committed control word and timeout limit.
// Assumes: cfg_hit marks an accepted write. The written value waits
// SETTLE_CYC cycles before it is committed, and busy is high in the meantime.
// A new accepted write restarts the wait.
module wdg_cfg
    import wdg_pkg::*;
#(
    parameter int           CNT_W      = 16,
    parameter int           SETTLE_CYC = 4,
    parameter logic [CNT_W-1:0] TOVAL_RST = CNT_W'(1000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hit,
    input  logic             sel_toval,
    input  ctrl_t            wr_ctrl,
    input  logic [CNT_W-1:0] wr_toval,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] toval,
    output logic             busy
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    ctrl_t            pend_ctrl;
    logic [CNT_W-1:0] pend_toval;
    logic             pend_sel;
    logic [SW-1:0]    settle_left;
    logic             commit;

    assign commit = busy && (settle_left == '0) && !cfg_hit;

    // Capture an accepted write and count down the settle interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            settle_left <= '0;
            pend_ctrl   <= CTRL_RESET;
            pend_toval  <= '0;
            pend_sel    <= 1'b0;
        end else if (cfg_hit) begin
            busy        <= 1'b1;
            settle_left <= SW'(SETTLE_CYC - 1);
            pend_ctrl   <= wr_ctrl;
            pend_toval  <= wr_toval;
            pend_sel    <= sel_toval;
        end else if (busy) begin
            if (settle_left == '0)
                busy <= 1'b0;
            else
                settle_left <= settle_left - 1'b1;
        end
    end

    // Move the staged value into the live register when settling ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= CTRL_RESET;
            toval <= TOVAL_RST;
        end else if (commit) begin
            if (pend_sel)
                toval <= pend_toval;
            else
                ctrl <= pend_ctrl;
        end
    end

endmodule

// File: rtl/wdg_count.sv
// Tick counter with a limit. Assumes the limit comes from the committed
// configuration. The count is cleared when the timer is disabled or on a
// refresh, and it stops once it reaches the limit.
module wdg_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wait_run,
    input  logic             stop_run,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic             tick_en,
    input  logic             refresh,
    input  logic [CNT_W-1:0] toval,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    logic at_limit;
    logic gate_ok;

    assign at_limit = (count >= toval);
    assign gate_ok  = (!wait_mode || wait_run) && (!stop_mode || stop_run);
    assign expired  = en && at_limit;

    // Advance on a permitted tick, clear when disabled or refreshed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!en || refresh)
            count <= '0;
        else if (tick_en && gate_ok && !at_limit)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/guarded_wdog.sv
// Top of the guarded watchdog: bus decode, read mux and the three stages.
// Assumes a single-cycle write strobe and a purely combinational read port
// with no side effects.
module guarded_wdog
    import wdg_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               UNLOCK_WIN = 16,
    parameter int               SETTLE_CYC = 4,
    parameter logic [CNT_W-1:0] TOVAL_RST  = CNT_W'(1000)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_en,
    input  logic        wait_mode,
    input  logic        stop_mode,
    output logic        expired
);
    logic             cnt_wr;
    logic             prot_wr;
    logic             cfg_hit;
    logic             unlocked;
    logic             busy;
    logic             refresh;
    ctrl_t            ctrl_live;
    ctrl_t            wr_ctrl;
    logic [CNT_W-1:0] toval_live;
    logic [CNT_W-1:0] count;

    // Decode writes by offset.
    assign cnt_wr  = bus_wr && (bus_addr == OFF_CNT);
    assign prot_wr = bus_wr && (bus_addr == OFF_CTRL || bus_addr == OFF_TOVAL);
    assign cfg_hit = prot_wr && unlocked;
    assign refresh = cnt_wr && (bus_wdata == KEY_REFRESH);

    // Map write-data bits onto the control fields.
    always_comb begin
        wr_ctrl.key32    = bus_wdata[B_KEY32];
        wr_ctrl.en       = bus_wdata[B_EN];
        wr_ctrl.upd      = bus_wdata[B_UPD];
        wr_ctrl.wait_run = bus_wdata[B_WAIT_RUN];
        wr_ctrl.stop_run = bus_wdata[B_STOP_RUN];
    end

    wdg_unlock #(.UNLOCK_WIN(UNLOCK_WIN)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_wr   (cnt_wr),
        .wdata    (bus_wdata),
        .key32    (ctrl_live.key32),
        .upd      (ctrl_live.upd),
        .cfg_hit  (cfg_hit),
        .unlocked (unlocked)
    );

    wdg_cfg #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .TOVAL_RST(TOVAL_RST)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_hit   (cfg_hit),
        .sel_toval (bus_addr == OFF_TOVAL),
        .wr_ctrl   (wr_ctrl),
        .wr_toval  (bus_wdata[CNT_W-1:0]),
        .ctrl      (ctrl_live),
        .toval     (toval_live),
        .busy      (busy)
    );

    wdg_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_live.en),
        .wait_run  (ctrl_live.wait_run),
        .stop_run  (ctrl_live.stop_run),
        .wait_mode (wait_mode),
        .stop_mode (stop_mode),
        .tick_en   (tick_en),
        .refresh   (refresh),
        .toval     (toval_live),
        .count     (count),
        .expired   (expired)
    );

    // Combinational read mux with status flags merged into the control word.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[B_KEY32]    = ctrl_live.key32;
                bus_rdata[B_OPEN]     = unlocked;
                bus_rdata[B_SETTLED]  = !busy;
                bus_rdata[B_EN]       = ctrl_live.en;
                bus_rdata[B_UPD]      = ctrl_live.upd;
                bus_rdata[B_WAIT_RUN] = ctrl_live.wait_run;
                bus_rdata[B_STOP_RUN] = ctrl_live.stop_run;
            end
            OFF_CNT:   bus_rdata = 32'(count);
            OFF_TOVAL: bus_rdata = 32'(toval_live);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_guard_chk.sv
// Property checker for guarded_wdog. It observes the bus, the window flag,
// the settle flag, the committed registers and the count, and is attached by bind.
module wdg_guard_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             unlocked,
    input logic             busy,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] toval,
    input logic [CNT_W-1:0] count
);
    logic prot_wr;
    assign prot_wr = bus_wr && (bus_addr == OFF_CTRL || bus_addr == OFF_TOVAL);

    // R2: the window opens only right after a counter write.
    assert_open_from_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == OFF_CNT));

    // R4: a protected write while locked and idle leaves the registers alone.
    assert_locked_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !unlocked && !busy) |=> ($stable(ctrl) && $stable(toval)));

    // R6: an accepted write closes the window and starts settling.
    assert_write_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && unlocked) |=> (busy && !unlocked));

    // R7: with updates forbidden, a closed window stays closed.
    assert_sealed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.upd && !unlocked) |=> !unlocked);

    // R8: the count only steps by one or returns to zero.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

    // R11: a refresh while enabled zeroes the count.
    assert_refresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CNT && bus_wdata == KEY_REFRESH && ctrl.en) |=> (count == '0));

endmodule

bind guarded_wdog wdg_guard_chk #(.CNT_W(CNT_W)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unlocked  (unlocked),
    .busy      (busy),
    .ctrl      (ctrl_live),
    .toval     (toval_live),
    .count     (count)
);

// File: tb/guarded_wdog_test.sv
`timescale 1ns/1ps
module guarded_wdog_test;
    localparam int         CW     = 8;
    localparam int         WIN    = 6;
    localparam int         SETTLE = 3;
    localparam logic [7:0] TRST   = 8'd20;

    localparam logic [31:0] KA  = 32'h0000_6A1C;
    localparam logic [31:0] KB  = 32'h0000_95E3;
    localparam logic [31:0] K32 = 32'h95E3_6A1C;
    localparam logic [31:0] RK  = 32'hB480_A602;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        wait_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic        expired;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    guarded_wdog #(.CNT_W(CW), .UNLOCK_WIN(WIN), .SETTLE_CYC(SETTLE), .TOVAL_RST(TRST)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .wait_mode(wait_mode), .stop_mode(stop_mode), .expired(expired)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic unlock16();
        wr(4'h4, KA);
        wr(4'h4, KB);
    endtask

    task automatic cfg(input logic [3:0] a, input logic [31:0] d, input bit m32);
        if (m32) wr(4'h4, K32); else unlock16();
        wr(a, d);
        idle(SETTLE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1 reset state
        rd(4'h0, d); check("R1 ctrl", d, 32'h420);
        rd(4'h4, d); check("R1 count", d, 0);
        rd(4'h8, d); check("R1 toval", d, 32'(TRST));
        check("R1 expired", 32'(expired), 0);

        // R4 locked writes ignored
        wr(4'h8, 32'd5); wr(4'h0, 32'hA3); idle(SETTLE);
        rd(4'h8, d); check("R4 toval", d, 32'(TRST));
        rd(4'h0, d); check("R4 ctrl", d, 32'h420);

        // R2 wrong second half, lone second half, then valid pair
        wr(4'h4, KA); wr(4'h4, 32'h1234);
        rd(4'h0, d); check("R2 bad pair", 32'(d[11]), 0);
        wr(4'h4, KB);
        rd(4'h0, d); check("R2 lone second", 32'(d[11]), 0);
        wr(4'h4, K32);
        rd(4'h0, d); check("R3 word key in 16-bit mode", 32'(d[11]), 0);
        unlock16();
        rd(4'h0, d); check("R2 valid pair", 32'(d[11]), 1);

        // R5 window length, sampled each cycle
        do_reset(); unlock16();
        for (int k = 0; k <= WIN; k++) begin
            rd(4'h0, d); check("R5 window flag", 32'(d[11]), (k < WIN) ? 1 : 0);
            idle(1);
        end

        // R5 acceptance sweep over every delay in and past the window
        for (int dly = 0; dly <= WIN + 1; dly++) begin
            do_reset(); unlock16(); idle(dly);
            wr(4'h8, 32'(40 + dly));
            rd(4'h0, d); check("R5 closed after write", 32'(d[11]), 0);
            idle(SETTLE);
            rd(4'h8, d); check("R5 accept by delay", d, (dly < WIN) ? 32'(40 + dly) : 32'(TRST));
        end

        // R5 second write after an accepted one is ignored
        do_reset(); unlock16(); wr(4'h8, 32'd9); wr(4'h0, 32'hA0); idle(SETTLE + 1);
        rd(4'h0, d); check("R5 second write", d, 32'h420);

        // R6 settle handshake, cycle by cycle
        do_reset(); unlock16(); wr(4'h8, 32'd77);
        for (int k = 0; k <= SETTLE; k++) begin
            rd(4'h0, d); check("R6 settled flag", 32'(d[10]), (k >= SETTLE) ? 1 : 0);
            rd(4'h8, d); check("R6 toval visibility", d, (k >= SETTLE) ? 32'd77 : 32'(TRST));
            idle(1);
        end

        // R3 32-bit key mode
        do_reset(); cfg(4'h0, 32'h2020, 0);
        rd(4'h0, d); check("R3 mode set", d, 32'h2420);
        unlock16();
        rd(4'h0, d); check("R3 pair rejected", 32'(d[11]), 0);
        wr(4'h4, K32);
        rd(4'h0, d); check("R3 word key", 32'(d[11]), 1);
        wr(4'h8, 32'd9); idle(SETTLE);
        rd(4'h8, d); check("R3 write after word key", d, 32'd9);

        // R7 sealed configuration
        do_reset(); cfg(4'h0, 32'h80, 0);
        rd(4'h0, d); check("R7 sealed ctrl", d, 32'h480);
        unlock16();
        rd(4'h0, d); check("R7 key ignored", 32'(d[11]), 0);
        wr(4'h8, 32'd3); idle(SETTLE);
        rd(4'h8, d); check("R7 toval kept", d, 32'(TRST));

        // R8 disabled holds zero
        do_reset(); tick(5);
        rd(4'h4, d); check("R8 disabled count", d, 0);

        // R8 R10 R11 sweep over limits and tick counts
        cfg(4'h0, 32'hA0, 0);
        for (int t = 1; t <= 4; t++) begin
            cfg(4'h8, 32'(t), 0);
            for (int n = 0; n <= t + 2; n++) begin
                wr(4'h4, RK);
                rd(4'h4, d); check("R11 refresh", d, 0);
                check("R11 expired low", 32'(expired), 0);
                tick(n);
                rd(4'h4, d); check("R8 R10 count", d, 32'((n < t) ? n : t));
                check("R10 expired", 32'(expired), (n >= t) ? 1 : 0);
            end
        end

        // R9 mode gating sweep
        cfg(4'h8, 32'd200, 0);
        for (int c = 0; c < 4; c++) begin
            cfg(4'h0, 32'hA0 | 32'(c), 0);
            for (int m = 0; m < 4; m++) begin
                logic [1:0] cb, mb;
                bit ok;
                cb = 2'(c); mb = 2'(m);
                wait_mode = mb[1]; stop_mode = mb[0];
                ok = (!mb[1] || cb[1]) && (!mb[0] || cb[0]);
                wr(4'h4, RK); tick(3);
                rd(4'h4, d); check("R9 gated count", d, ok ? 32'd3 : 32'd0);
            end
            wait_mode = 1'b0; stop_mode = 1'b0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule